// File: doc/BRIEF.md
# Write-Only I2C Current-Setting Receiver

This block is the serial control front end of a constant-current coil driver. It is an I2C target that only accepts writes. A system clock samples the SCL and SDA lines, and the block finds start and stop conditions on the resynchronised values. It matches a fixed 7-bit target address, acknowledges each accepted byte by pulling SDA low, and collects a three-byte frame: the address byte followed by two data bytes.

The 8-bit current code is split across the two data bytes. The first data byte carries a power-down flag, one unused bit and the upper six code bits. The second data byte carries the two lowest code bits and six unused bits. The code and the flag are committed together, with a one-cycle update strobe, once the last byte has been acknowledged. A frame that ends early leaves the outputs as they were. An active-low power-down/reset input clears everything. After reset the code is zero and power-down is asserted.

Top module: `coil_setpoint_rx`

## Requirements
- R1: While `pd_rst_n` is low, and after it rises, `code_o` is 0, `pd_o` is 1, `sda_pull_o` is 0 and `update_o` is 0 until a valid frame commits.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Both are detected on the two-flop-synchronised lines. A start at any point begins a new frame, and a stop ends the current frame.
- R3: The first byte after a start is accepted when its seven upper bits are 0110011 and its lowest bit is 0 (write). The block then pulls SDA low after the eighth SCL falling edge and releases it at the ninth SCL falling edge.
- R4: If the address does not match, or the lowest bit of the first byte is 1, no byte of that frame is acknowledged and the outputs do not change until the next start or stop.
- R5: In an addressed frame, the second and third bytes are each acknowledged in their ninth clock. SDA is released after each ninth falling edge.
- R6: Bytes are received MSB first. The committed code is {byte2[5:0], byte3[7:6]} and the power-down output is byte2[7]. Bit 6 of byte2 and bits 5..0 of byte3 have no effect.
- R7: The code and the power-down flag are committed together, with `update_o` high for exactly one clock cycle, after the ninth SCL falling edge of the third byte.
- R8: A stop or repeated start before the third byte is acknowledged leaves `code_o` and `pd_o` unchanged. A full frame after a repeated start commits normally.
- R9: Bytes that follow the third byte are not acknowledged and do not change the outputs.
- R10: `code_o` and `pd_o` change only in the cycle in which `update_o` is high. Codes 0 and 255 are both committed as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz for a 400 kHz bus |
| pd_rst_n | input | 1 | Active-low power-down and asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| code_o | output | 8 | Committed current-setting code, 0 = no current, 255 = full scale |
| pd_o | output | 1 | Committed power-down flag, 1 = powered down |
| update_o | output | 1 | One-cycle strobe marking a commit of code and flag |

## Verification
On every cycle, the assertions check these rules: the acknowledge drive rises only right after an SCL falling edge and drops only after a falling edge, start or stop; the update strobe lasts one cycle and always follows the receiver's commit; and the code and power-down outputs never move outside a strobe cycle. Only the bench scenarios can show that the right bits land in the right fields. The same holds for the other frame-level cases: no acknowledge for a wrong address or a read bit, no change after a truncated frame or an extra byte, and that a repeated start really restarts the frame.

// File: rtl/coil_setpoint_pkg.sv
package coil_setpoint_pkg;

  localparam int BYTE_W      = 8;
  localparam int CODE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int FRAME_BYTES = 3;
  localparam int IDX_W       = $clog2(FRAME_BYTES + 1);
  localparam int CNT_W       = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_ACK   = 2'd2,
    RX_SKIP  = 2'd3
  } rx_state_t;

  // address byte: upper seven bits are the target, bit 0 must be write (0)
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] dev);
    return (b[BYTE_W-1:1] == dev) && (b[0] == 1'b0);
  endfunction

  // code high part sits in byte two bits 5..0, low part in byte three bits 7..6
  function automatic logic [CODE_W-1:0] join_code(input logic [BYTE_W-1:0] hi_b,
                                                  input logic [BYTE_W-1:0] lo_b);
    return {hi_b[5:0], lo_b[7:6]};
  endfunction

  function automatic logic pd_flag(input logic [BYTE_W-1:0] hi_b);
    return hi_b[7];
  endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/bus_event_det.sv
module bus_event_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_evt =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_evt  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import coil_setpoint_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b0110011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              ack_pull,
  output logic              commit,
  output logic [CODE_W-1:0] code_new,
  output logic              pd_new,
  output logic              idle
);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] hold_hi;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      hold_hi  <= '0;
      ack_pull <= 1'b0;
      commit   <= 1'b0;
      code_new <= '0;
      pd_new   <= 1'b1;
    end else begin
      commit <= 1'b0;
      if (start_evt) begin
        state    <= RX_SHIFT;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_pull <= 1'b0;
      end else if (stop_evt) begin
        state    <= RX_IDLE;
        ack_pull <= 1'b0;
      end else begin
        unique case (state)
          RX_SHIFT: begin
            if (scl_rise && bit_cnt < LAST_BIT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              if (byte_idx == '0) begin
                if (addr_hit(shreg, DEV_ADDR)) begin
                  state    <= RX_ACK;
                  ack_pull <= 1'b1;
                end else begin
                  state <= RX_SKIP;
                end
              end else begin
                if (byte_idx == IDX_W'(1)) hold_hi <= shreg;
                state    <= RX_ACK;
                ack_pull <= 1'b1;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              ack_pull <= 1'b0;
              bit_cnt  <= '0;
              if (byte_idx == LAST_IDX) begin
                commit   <= 1'b1;
                code_new <= join_code(hold_hi, shreg);
                pd_new   <= pd_flag(hold_hi);
                state    <= RX_SKIP;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                state    <= RX_SHIFT;
              end
            end
          end
          RX_SKIP: ;
          default: ;
        endcase
      end
    end
  end

  assign idle = (state == RX_IDLE);

endmodule

// File: rtl/setpoint_reg.sv
module setpoint_reg
  import coil_setpoint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CODE_W-1:0] code_new,
  input  logic              pd_new,
  output logic [CODE_W-1:0] code_o,
  output logic              pd_o,
  output logic              update_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o   <= '0;
      pd_o     <= 1'b1;
      update_o <= 1'b0;
    end else begin
      update_o <= commit;
      if (commit) begin
        code_o <= code_new;
        pd_o   <= pd_new;
      end
    end
  end

endmodule

// File: rtl/coil_setpoint_rx.sv
module coil_setpoint_rx
  import coil_setpoint_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0110011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pd_rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] code_o,
  output logic       pd_o,
  output logic       update_o
);

  logic [1:0] line_s;
  logic       scl_rise_w, scl_fall_w, start_w, stop_w;
  logic       commit_w, pd_new_w, rx_idle_w;
  logic [CODE_W-1:0] code_new_w;

  bus_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (pd_rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  bus_event_det u_evt (
    .clk       (clk),
    .rst_n     (pd_rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_evt (start_w),
    .stop_evt  (stop_w)
  );

  frame_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk       (clk),
    .rst_n     (pd_rst_n),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_evt (start_w),
    .stop_evt  (stop_w),
    .ack_pull  (sda_pull_o),
    .commit    (commit_w),
    .code_new  (code_new_w),
    .pd_new    (pd_new_w),
    .idle      (rx_idle_w)
  );

  setpoint_reg u_reg (
    .clk      (clk),
    .rst_n    (pd_rst_n),
    .commit   (commit_w),
    .code_new (code_new_w),
    .pd_new   (pd_new_w),
    .code_o   (code_o),
    .pd_o     (pd_o),
    .update_o (update_o)
  );

endmodule

// File: rtl/coil_setpoint_rx_chk.sv
module coil_setpoint_rx_chk (
  input logic       clk,
  input logic       pd_rst_n,
  input logic       sda_pull_o,
  input logic [7:0] code_o,
  input logic       pd_o,
  input logic       update_o,
  input logic       scl_fall_w,
  input logic       start_w,
  input logic       stop_w,
  input logic       commit_w,
  input logic       rx_idle_w
);

  AST_RESET_STATE: assert property (@(posedge clk)
    !pd_rst_n |=> (code_o == 8'd0 && pd_o && !update_o && !sda_pull_o)); // R1

  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!pd_rst_n)
    rx_idle_w |-> !sda_pull_o); // R2

  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!pd_rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall_w)); // R3

  AST_RELEASE_AT_EDGE: assert property (@(posedge clk) disable iff (!pd_rst_n)
    $fell(sda_pull_o) |-> $past(scl_fall_w || start_w || stop_w)); // R5

  AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!pd_rst_n)
    update_o |=> !update_o); // R7

  AST_UPDATE_FROM_COMMIT: assert property (@(posedge clk) disable iff (!pd_rst_n)
    update_o |-> $past(commit_w)); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!pd_rst_n)
    stop_w |=> !sda_pull_o); // R8

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!pd_rst_n)
    !$stable(code_o) |-> update_o); // R10

  AST_PD_HOLDS: assert property (@(posedge clk) disable iff (!pd_rst_n)
    !$stable(pd_o) |-> update_o); // R10

endmodule

bind coil_setpoint_rx coil_setpoint_rx_chk u_chk (
  .clk        (clk),
  .pd_rst_n   (pd_rst_n),
  .sda_pull_o (sda_pull_o),
  .code_o     (code_o),
  .pd_o       (pd_o),
  .update_o   (update_o),
  .scl_fall_w (scl_fall_w),
  .start_w    (start_w),
  .stop_w     (stop_w),
  .commit_w   (commit_w),
  .rx_idle_w  (rx_idle_w)
);

// File: tb/test_coil_setpoint_rx.sv
`timescale 1ns/1ps
module test_coil_setpoint_rx;

  localparam int Q = 8;               // quarter bit period in clocks
  localparam logic [7:0] ADDR_W_BYTE = 8'h66; // 0110011 + write bit

  logic clk = 1'b0;
  logic pd_rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_o, pd_o, update_o;
  logic [7:0] code_o;
  wire  sda_line = sda_m & ~sda_pull_o;

  int n_tests = 0;
  int n_fail  = 0;
  int upd_cnt = 0;

  always #2.5 clk = ~clk;

  coil_setpoint_rx i_coil_setpoint_rx (
    .clk        (clk),
    .pd_rst_n   (pd_rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull_o),
    .code_o     (code_o),
    .pd_o       (pd_o),
    .update_o   (update_o)
  );

  always @(negedge clk) if (pd_rst_n && update_o) upd_cnt++;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] hi_byte(input logic [7:0] code, input logic pd, input logic dc);
    return {pd, dc, code[7:2]};
  endfunction

  function automatic logic [7:0] lo_byte(input logic [7:0] code, input logic [5:0] dc);
    return {code[1:0], dc};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  // sends one byte, returns acknowledge seen and whether SDA was released after it
  task automatic bus_byte(input logic [7:0] b, output logic acked, output logic released);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q);
      sda_m = b[i]; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2*Q);
      scl_m = 1'b0;
    end
    wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    acked = ~sda_line; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
    released = ~sda_pull_o;
  endtask

  task automatic full_frame(input logic [7:0] b2, input logic [7:0] b3,
                            output logic a1, output logic a2, output logic a3);
    logic rel;
    bus_start();
    bus_byte(ADDR_W_BYTE, a1, rel);
    bus_byte(b2, a2, rel);
    bus_byte(b3, a3, rel);
    bus_stop();
  endtask

  task automatic do_reset();
    pd_rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    wait_clk(4);
    check(code_o == 8'd0, "R1 code during reset", code_o, 0);
    check(pd_o == 1'b1, "R1 pd during reset", pd_o, 1);
    check(sda_pull_o == 1'b0 && update_o == 1'b0, "R1 pull/update during reset",
          {sda_pull_o, update_o}, 0);
    pd_rst_n = 1'b1;
    wait_clk(4);
    check(code_o == 8'd0 && pd_o == 1'b1, "R1 state after reset", {pd_o, code_o}, 256);
  endtask

  task automatic t_basic_write();
    logic a1, a2, a3, rel;
    int u0;
    u0 = upd_cnt;
    bus_start();
    bus_byte(ADDR_W_BYTE, a1, rel);
    check(a1, "R3 address ack", a1, 1);
    check(rel, "R3 release after address ack", rel, 1);
    bus_byte(hi_byte(8'hA5, 1'b0, 1'b1), a2, rel);
    check(a2 && rel, "R5 byte2 ack and release", {a2, rel}, 3);
    check(code_o == 8'd0 && upd_cnt == u0, "R10 no change before byte3", code_o, 0);
    bus_byte(lo_byte(8'hA5, 6'b101010), a3, rel);
    check(a3 && rel, "R5 byte3 ack and release", {a3, rel}, 3);
    bus_stop();
    check(code_o == 8'hA5, "R6 code A5", code_o, 8'hA5);
    check(pd_o == 1'b0, "R6 pd cleared", pd_o, 0);
    check(upd_cnt == u0 + 1, "R7 single update", upd_cnt - u0, 1);
  endtask

  task automatic t_boundaries();
    logic a1, a2, a3;
    full_frame(hi_byte(8'hFF, 1'b1, 1'b0), lo_byte(8'hFF, 6'b000000), a1, a2, a3);
    check(code_o == 8'hFF && pd_o == 1'b1, "R10 full scale code with pd set",
          {pd_o, code_o}, 9'h1FF);
    full_frame(hi_byte(8'h00, 1'b0, 1'b1), lo_byte(8'h00, 6'b111111), a1, a2, a3);
    check(code_o == 8'h00 && pd_o == 1'b0, "R6 zero code, dont-care bits set",
          {pd_o, code_o}, 0);
    full_frame(hi_byte(8'h03, 1'b0, 1'b0), lo_byte(8'h03, 6'b010101), a1, a2, a3);
    check(code_o == 8'h03, "R6 low code bits from byte3", code_o, 3);
    full_frame(hi_byte(8'h5C, 1'b0, 1'b1), lo_byte(8'h5C, 6'b000000), a1, a2, a3);
    check(code_o == 8'h5C, "R6 high code bits from byte2", code_o, 8'h5C);
  endtask

  task automatic t_bad_address(input logic [7:0] ab, input string tag);
    logic a1, a2, a3, rel;
    int u0;
    u0 = upd_cnt;
    bus_start();
    bus_byte(ab, a1, rel);
    bus_byte(hi_byte(8'h11, 1'b1, 1'b0), a2, rel);
    bus_byte(lo_byte(8'h11, 6'b0), a3, rel);
    bus_stop();
    check(!a1 && !a2 && !a3, tag, {a1, a2, a3}, 0);
    check(code_o == 8'h5C && upd_cnt == u0, "R4 outputs unchanged", code_o, 8'h5C);
  endtask

  task automatic t_truncated();
    logic a1, a2, a3, rel;
    int u0;
    u0 = upd_cnt;
    bus_start();
    bus_byte(ADDR_W_BYTE, a1, rel);
    bus_byte(hi_byte(8'hEE, 1'b1, 1'b0), a2, rel);
    bus_stop();
    check(code_o == 8'h5C && pd_o == 1'b0 && upd_cnt == u0, "R8 stop after byte2",
          code_o, 8'h5C);
    bus_start();
    bus_byte(ADDR_W_BYTE, a1, rel);
    bus_byte(hi_byte(8'hEE, 1'b1, 1'b0), a2, rel);
    bus_rstart();
    check(code_o == 8'h5C && upd_cnt == u0, "R8 repeated start after byte2", code_o, 8'h5C);
    bus_byte(ADDR_W_BYTE, a1, rel);
    bus_byte(hi_byte(8'h39, 1'b0, 1'b0), a2, rel);
    bus_byte(lo_byte(8'h39, 6'b110011), a3, rel);
    bus_stop();
    check(a1 && a2 && a3, "R2 repeated start begins new frame", {a1, a2, a3}, 7);
    check(code_o == 8'h39 && upd_cnt == u0 + 1, "R8 commit after repeated start",
          code_o, 8'h39);
  endtask

  task automatic t_extra_byte();
    logic a1, a2, a3, a4, rel;
    bus_start();
    bus_byte(ADDR_W_BYTE, a1, rel);
    bus_byte(hi_byte(8'h81, 1'b0, 1'b0), a2, rel);
    bus_byte(lo_byte(8'h81, 6'b0), a3, rel);
    bus_byte(8'hFF, a4, rel);
    bus_stop();
    check(!a4, "R9 fourth byte not acked", a4, 0);
    check(code_o == 8'h81, "R9 outputs keep frame value", code_o, 8'h81);
  endtask

  task automatic t_mid_reset();
    logic a1, rel;
    bus_start();
    bus_byte(ADDR_W_BYTE, a1, rel);
    pd_rst_n = 1'b0; wait_clk(2);
    check(code_o == 8'd0 && pd_o == 1'b1 && !sda_pull_o, "R1 reset mid-frame",
          {pd_o, code_o}, 256);
    pd_rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1; wait_clk(4*Q);
  endtask

  initial begin
    do_reset();
    t_basic_write();
    t_boundaries();
    t_bad_address(8'h68, "R4 wrong address not acked");
    t_bad_address(8'h67, "R4 read bit not acked");
    t_truncated();
    t_extra_byte();
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule